// File: doc/BRIEF.md
# Region Address Relocation Unit

This unit turns a logical address issued by a processor into a physical address with a base-plus-bound scheme. It holds three independent translation pairs, one for each of a program's code, data and stack areas. Each pair is a relocation base and a limit. A request carries a logical address and a region selector. One cycle later the unit answers with either the relocated physical address or a protection trap.

System software loads a pair through a single-cycle write port. This happens, for example, when a swapped-out process is restored to memory and its areas land at new physical locations. A write replaces the base and the limit of one region together. A translation therefore always uses a complete pair, either the old one or the new one.

Reset is asynchronous and active low, and its release is synchronised inside the unit. After reset every limit is zero, so every access traps until the pairs have been loaded.

Top module: `reloc_unit`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_trap` and `rsp_paddr` are 0. All limits start at zero, so any request made before the first load traps.
- R2: `rsp_valid` is 1 in exactly the cycle that follows a cycle with `req` = 1, and 0 otherwise. Back-to-back requests give back-to-back responses.
- R3: A legal request returns `rsp_paddr` = selected base + zero-extended logical address, modulo 2^PA_W.
- R4: A request whose logical address is greater than or equal to the selected limit returns `rsp_trap` = 1 and `rsp_paddr` = 0. An address of limit−1 is legal, and an address equal to the limit traps.
- R5: Region select encoding: 0 selects code, 1 selects data and 2 selects stack. Each region uses only its own pair.
- R6: Region select value 3 is reserved. A request with it always traps, and a write with it changes no pair.
- R7: A write with `wr_en` = 1 loads both the base and the limit of `wr_region` at the next clock edge. A request in the same cycle as the write uses the old pair, and a request in any later cycle uses the new pair.
- R8: The limit is compared against the logical address before relocation. A legal address stays legal even when its physical address exceeds the limit.
- R9: While `rsp_valid` is 0, `rsp_trap` and `rsp_paddr` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load a translation pair this cycle |
| wr_region | input | 2 | Region whose pair is loaded |
| wr_base | input | PA_W (20) | New relocation base |
| wr_limit | input | LA_W (16) | New limit, in logical-address units |
| req | input | 1 | Translation request |
| req_region | input | 2 | Region of the request (0 code, 1 data, 2 stack) |
| req_laddr | input | LA_W (16) | Logical address |
| rsp_valid | output | 1 | Response present (one cycle after `req`) |
| rsp_trap | output | 1 | Protection trap for this response |
| rsp_paddr | output | PA_W (20) | Physical address, 0 on a trap |

## Verification
Requests are issued with logical addresses at limit−1, at the limit and at zero. These points separate a strict comparison from an inclusive one, and show that an unloaded pair traps. Each region is loaded with its own base, so a wrong region decode produces a visibly wrong address. The stack base sits near the top of the physical space, which exercises wrap-around. Writes placed in the same cycle as a request show whether the old pair or the new one is used, and a reserved-region write followed by reads of all three regions shows that it was ignored. A long pseudo-random run of back-to-back and idle cycles, compared every clock against a behavioural model, covers response timing and the zeroed idle outputs.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int NREG  = 3;
  localparam int RSEL_W = 2;

  typedef enum logic [RSEL_W-1:0] {
    RGN_CODE  = 2'd0,
    RGN_DATA  = 2'd1,
    RGN_STACK = 2'd2
  } region_e;
endpackage

// File: rtl/reloc_rst_sync.sv
module reloc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/reloc_regfile.sv
module reloc_regfile
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RSEL_W-1:0] wr_region,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [LA_W-1:0]   wr_limit,
  input  logic [RSEL_W-1:0] rd_region,
  output logic              sel_ok,
  output logic [PA_W-1:0]   sel_base,
  output logic [LA_W-1:0]   sel_limit
);
  logic [NREG-1:0][PA_W-1:0] base_q;
  logic [NREG-1:0][LA_W-1:0] limit_q;

  for (genvar g = 0; g < NREG; g++) begin : g_pair
    logic ld_en;
    assign ld_en = wr_en && (int'(wr_region) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (ld_en) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
      end
    end
  end

  always_comb begin
    sel_ok    = 1'b0;
    sel_base  = '0;
    sel_limit = '0;
    for (int i = 0; i < NREG; i++) begin
      if (int'(rd_region) == i) begin
        sel_ok    = 1'b1;
        sel_base  = base_q[i];
        sel_limit = limit_q[i];
      end
    end
  end

  // R6
  bad_region_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_region) >= NREG) |=> ($stable(base_q) && $stable(limit_q)));

  // R7
  pair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_region) < NREG) |=> (limit_q[$past(wr_region)] == $past(wr_limit)));
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [LA_W-1:0] req_laddr,
  input  logic            sel_ok,
  input  logic [PA_W-1:0] sel_base,
  input  logic [LA_W-1:0] sel_limit,
  output logic            rsp_valid,
  output logic            rsp_trap,
  output logic [PA_W-1:0] rsp_paddr
);
  logic            in_bounds;
  logic            valid_d, trap_d;
  logic [PA_W-1:0] paddr_d;

  always_comb begin
    in_bounds = sel_ok && (req_laddr < sel_limit);
    valid_d   = req;
    trap_d    = req && !in_bounds;
    paddr_d   = (req && in_bounds) ? (sel_base + PA_W'(req_laddr)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_trap  <= trap_d;
      rsp_paddr <= paddr_d;
    end
  end

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  // R4
  over_limit_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_laddr >= sel_limit) |=> rsp_trap);

  // R4
  trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_paddr == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_trap && rsp_paddr == '0));
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RSEL_W-1:0] wr_region,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [LA_W-1:0]   wr_limit,
  input  logic              req,
  input  logic [RSEL_W-1:0] req_region,
  input  logic [LA_W-1:0]   req_laddr,
  output logic              rsp_valid,
  output logic              rsp_trap,
  output logic [PA_W-1:0]   rsp_paddr
);
  logic            rst_n_s;
  logic            sel_ok;
  logic [PA_W-1:0] sel_base;
  logic [LA_W-1:0] sel_limit;

  reloc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  reloc_regfile #(.LA_W(LA_W), .PA_W(PA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .wr_region (wr_region),
    .wr_base   (wr_base),
    .wr_limit  (wr_limit),
    .rd_region (req_region),
    .sel_ok    (sel_ok),
    .sel_base  (sel_base),
    .sel_limit (sel_limit)
  );

  reloc_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req       (req),
    .req_laddr (req_laddr),
    .sel_ok    (sel_ok),
    .sel_base  (sel_base),
    .sel_limit (sel_limit),
    .rsp_valid (rsp_valid),
    .rsp_trap  (rsp_trap),
    .rsp_paddr (rsp_paddr)
  );

  // R6
  reserved_region_trap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req && int'(req_region) >= NREG) |=> rsp_trap);
endmodule

// File: tb/reloc_unit_test.sv
module reloc_unit_test;
  localparam int LA_W = 16;
  localparam int PA_W = 20;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [1:0]      wr_region;
  logic [PA_W-1:0] wr_base;
  logic [LA_W-1:0] wr_limit;
  logic            req;
  logic [1:0]      req_region;
  logic [LA_W-1:0] req_laddr;
  logic            rsp_valid, rsp_trap;
  logic [PA_W-1:0] rsp_paddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  longint mdl_base [3];
  longint mdl_lim  [3];

  always #2 clk = ~clk;

  reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_region(wr_region),
    .wr_base(wr_base), .wr_limit(wr_limit), .req(req), .req_region(req_region),
    .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_trap(rsp_trap),
    .rsp_paddr(rsp_paddr)
  );

  task automatic check(string tag, bit ev, bit et, longint ep);
    total++;
    if (rsp_valid !== ev || rsp_trap !== et || rsp_paddr !== PA_W'(ep)) begin
      bad++;
      $display("FAIL %s: actual valid=%0b trap=%0b paddr=%h expected valid=%0b trap=%0b paddr=%h",
               tag, rsp_valid, rsp_trap, rsp_paddr, ev, et, PA_W'(ep));
    end
  endtask

  // One clock: drive, predict from the model, advance, compare after the edge.
  task automatic step(string tag, bit rq, int rg, int la, bit we, int wrg, longint wb, int wl);
    bit ok, ev, et;
    longint ep;
    req = rq; req_region = 2'(rg); req_laddr = LA_W'(la);
    wr_en = we; wr_region = 2'(wrg); wr_base = PA_W'(wb); wr_limit = LA_W'(wl);
    ok = (rg < 3) && (longint'(la) < mdl_lim[rg < 3 ? rg : 0]);
    ev = rq;
    et = rq && !ok;
    ep = (rq && ok) ? ((mdl_base[rg] + la) % (longint'(1) << PA_W)) : 0;
    if (we && wrg < 3) begin
      mdl_base[wrg] = wb % (longint'(1) << PA_W);
      mdl_lim[wrg]  = wl % (1 << LA_W);
    end
    @(posedge clk);
    #1;
    check(tag, ev, et, ep);
  endtask

  task automatic ld(int rg, longint b, int l);
    step("R7", 0, 0, 0, 1, rg, b, l);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 3; i++) begin mdl_base[i] = 0; mdl_lim[i] = 0; end
    rst_n = 1'b0; wr_en = 0; wr_region = 0; wr_base = 0; wr_limit = 0;
    req = 0; req_region = 0; req_laddr = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after reset", 0, 0, 0);
    // R1: unloaded limits trap
    step("R1 code", 1, 0, 0, 0, 0, 0, 0);
    step("R1 data", 1, 1, 0, 0, 0, 0, 0);
    step("R1 stack", 1, 2, 0, 0, 0, 0, 0);
    step("R9 idle", 0, 0, 5, 0, 0, 0, 0);
    // load the three pairs
    ld(0, 'h01000, 'h0400);
    ld(1, 'h20000, 'h1000);
    ld(2, 'hFFF00, 'h0200);
    // R4 boundary, R3 relocation, R5 region decode
    step("R4 limit-1", 1, 0, 'h3FF, 0, 0, 0, 0);
    step("R4 at limit", 1, 0, 'h400, 0, 0, 0, 0);
    step("R5 data", 1, 1, 'h100, 0, 0, 0, 0);
    step("R3 wrap", 1, 2, 'h1FF, 0, 0, 0, 0);
    step("R5 stack over", 1, 2, 'h200, 0, 0, 0, 0);
    step("R8 pre-relocation", 1, 1, 'hFFF, 0, 0, 0, 0);
    // R6 reserved region
    step("R6 req", 1, 3, 0, 0, 0, 0, 0);
    step("R6 write", 0, 0, 0, 1, 3, 'h5, 'hFFFF);
    step("R6 code kept", 1, 0, 'h10, 0, 0, 0, 0);
    step("R6 data kept", 1, 1, 'h10, 0, 0, 0, 0);
    step("R6 stack kept", 1, 2, 'h10, 0, 0, 0, 0);
    // R7 write coinciding with a request
    step("R7 same cycle old pair", 1, 1, 'h20, 1, 1, 'h30000, 'h10);
    step("R7 new limit", 1, 1, 'h20, 0, 0, 0, 0);
    step("R7 new base", 1, 1, 'h0F, 0, 0, 0, 0);
    // mixed pseudo-random traffic (R2, R3, R4, R9)
    seed = 17;
    for (int i = 0; i < 300; i++) begin
      int r, la, rg;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      r  = seed;
      rg = (r >> 4) % 4;
      la = (r >> 8) % 'h1400;
      if ((r % 11) == 0)
        step("R7 mix", r[1], rg, la, 1, (r >> 2) % 4, longint'(r >> 3), (r >> 6) % 'h2000);
      else
        step("R2 mix", (r % 5) != 0, rg, la, 0, 0, 0, 0);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule